// File: doc/BRIEF.md
# Mine Pump Safety Controller

This block is a synchronous controller for a mine drainage pump. It reads two sensor flags, one for high water and one for high methane, and drives a pump enable and an alarm. One rule always holds: the pump never runs in a cycle in which methane is high. The alarm is raised within a fixed number of cycles once either hazard persists. It is cleared within a fixed number of cycles once both sensors have been quiet.

Many output choices meet those hard rules. A 2-bit policy input picks the preference used among them:

- Keep the pump off until running it can no longer be put off.
- Run the pump as early as water allows.
- Run the pump unless methane was seen recently.

Saturating run-length counters track each condition. The current count of consecutive high-water cycles is brought out as status.

Top module: `mine_pump_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, alarm is low and wet_count is 0. The policy in force is code 0, so the pump is off while water is low.
- R2: In any cycle in which gas_hi is high, pump_on is low in that same cycle, whatever the policy.
- R3: Once water_hi has been sampled high on WATER_BOUND consecutive clock edges (default 3), alarm is high after that edge.
- R4: Once gas_hi has been sampled high on GAS_BOUND consecutive clock edges (default 3), alarm is high after that edge.
- R5: Alarm is low after CLEAR_BOUND consecutive edges (default 3) on which both water_hi and gas_hi were sampled low. Apart from R3 and R4, a shorter quiet run leaves alarm unchanged.
- R6: Policy code 0 (lazy) drives pump_on high only when water_hi is high, gas_hi is low, and wet_count is at least WATER_BOUND-1.
- R7: Policy codes 1 and 3 (eager) drive pump_on equal to water_hi AND NOT gas_hi.
- R8: Policy code 2 (methane history) drives pump_on high exactly when gas_hi is low now and was sampled low on each of the previous two edges. Water level does not affect this decision.
- R9: The policy input is sampled on the clock edge. A new code governs pump_on only from the cycle after the edge that samples it.
- R10: wet_count equals the number of consecutive edges on which water_hi was sampled high. It is 0 after an edge that samples water_hi low and saturates at 2^CNT_W-1 (15 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| water_hi | input | 1 | High water level flag |
| gas_hi | input | 1 | High methane level flag |
| policy | input | 2 | Preference policy: 0 lazy, 1 or 3 eager, 2 methane history |
| pump_on | output | 1 | Pump enable |
| alarm | output | 1 | Alarm output |
| wet_count | output | CNT_W | Consecutive high-water cycle count, saturating |

## Verification
The bench checks the lazy policy at the exact cycle its wait ends. A design that counted one edge differently would start the pump a cycle early or late.

It also interrupts a quiet run with a single wet cycle. A controller that never reset its clearing count would drop the alarm too soon.

The methane-history window is stepped through both past cycles. A window one cycle short would restart the pump one cycle early.

The remaining cases cover four things:
- Policy changes land in the cycle after the change, so a controller reacting to the raw input would differ in the change cycle.
- Code 3 acts as eager, so a lazy fallback would keep the pump off.
- The counter saturates at 15, so a wrapping counter would read 0.
- Methane masks the pump under the eager policy.

// File: rtl/mine_pump_ctrl.sv
module mine_pump_ctrl #(
  parameter int WATER_BOUND = 3,
  parameter int GAS_BOUND   = 3,
  parameter int CLEAR_BOUND = 3,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             water_hi,
  input  logic             gas_hi,
  input  logic [1:0]       policy,
  output logic             pump_on,
  output logic             alarm,
  output logic [CNT_W-1:0] wet_count
);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] WATER_LIM = CNT_W'(WATER_BOUND);
  localparam logic [CNT_W-1:0] GAS_LIM   = CNT_W'(GAS_BOUND);
  localparam logic [CNT_W-1:0] CLEAR_LIM = CNT_W'(CLEAR_BOUND);
  localparam logic [CNT_W-1:0] LAZY_LIM  = CNT_W'(WATER_BOUND - 1);

  function automatic logic [CNT_W-1:0] run_next(input logic hit, input logic [CNT_W-1:0] cur);
    if (!hit) return '0;
    return (cur == CNT_MAX) ? cur : cur + 1'b1;
  endfunction

  logic [CNT_W-1:0] wet_cnt, gas_cnt, calm_cnt;
  logic [CNT_W-1:0] wet_nx, gas_nx, calm_nx;
  logic [1:0]       gas_hist;
  logic [1:0]       pol_q;
  logic             want_pump;
  logic             raise, drop;

  assign wet_nx  = run_next(water_hi, wet_cnt);
  assign gas_nx  = run_next(gas_hi, gas_cnt);
  assign calm_nx = run_next(!water_hi && !gas_hi, calm_cnt);

  assign raise = (wet_nx >= WATER_LIM) || (gas_nx >= GAS_LIM);
  assign drop  = calm_nx >= CLEAR_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wet_cnt  <= '0;
      gas_cnt  <= '0;
      calm_cnt <= '0;
      gas_hist <= '0;
      pol_q    <= 2'd0;
      alarm    <= 1'b0;
    end else begin
      wet_cnt  <= wet_nx;
      gas_cnt  <= gas_nx;
      calm_cnt <= calm_nx;
      gas_hist <= {gas_hist[0], gas_hi};
      pol_q    <= policy;
      if (raise)     alarm <= 1'b1;
      else if (drop) alarm <= 1'b0;
    end
  end

  always_comb begin
    case (pol_q)
      2'd0:    want_pump = water_hi && (wet_cnt >= LAZY_LIM);
      2'd2:    want_pump = !(|gas_hist);
      default: want_pump = water_hi;
    endcase
  end

  assign pump_on   = want_pump && !gas_hi;
  assign wet_count = wet_cnt;
endmodule

// File: rtl/mine_pump_ctrl_chk.sv
module mine_pump_ctrl_chk #(
  parameter int WATER_BOUND = 3,
  parameter int GAS_BOUND   = 3,
  parameter int CLEAR_BOUND = 3,
  parameter int CNT_W       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             water_hi,
  input logic             gas_hi,
  input logic [1:0]       policy,
  input logic             pump_on,
  input logic             alarm,
  input logic [CNT_W-1:0] wet_count
);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] WATER_LIM = CNT_W'(WATER_BOUND);
  localparam logic [CNT_W-1:0] GAS_LIM   = CNT_W'(GAS_BOUND);
  localparam logic [CNT_W-1:0] CLEAR_LIM = CNT_W'(CLEAR_BOUND);

  logic [CNT_W-1:0] gas_run, calm_run;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gas_run  <= '0;
      calm_run <= '0;
      armed    <= 1'b0;
    end else begin
      armed    <= 1'b1;
      gas_run  <= !gas_hi ? '0 : (gas_run == CNT_MAX ? gas_run : gas_run + 1'b1);
      calm_run <= (water_hi || gas_hi) ? '0 : (calm_run == CNT_MAX ? calm_run : calm_run + 1'b1);
    end
  end

  assert_gas_blocks_pump_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gas_hi |-> !pump_on);

  assert_water_alarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wet_count >= WATER_LIM) |-> alarm);

  assert_gas_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gas_run >= GAS_LIM) |-> alarm);

  assert_calm_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (calm_run >= CLEAR_LIM) |-> !alarm);

  assert_eager_pumps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(policy[0]) && !$past(policy[1]) && water_hi && !gas_hi) |-> pump_on);

  assert_wet_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !water_hi |=> (wet_count == '0));

  assert_wet_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wet_count == CNT_MAX && water_hi) |=> (wet_count == CNT_MAX));
endmodule

bind mine_pump_ctrl mine_pump_ctrl_chk #(
  .WATER_BOUND(WATER_BOUND), .GAS_BOUND(GAS_BOUND),
  .CLEAR_BOUND(CLEAR_BOUND), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .water_hi(water_hi), .gas_hi(gas_hi),
  .policy(policy), .pump_on(pump_on), .alarm(alarm), .wet_count(wet_count)
);

// File: tb/mine_pump_ctrl_test.sv
`timescale 1ns/1ps
module mine_pump_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       water_hi = 1'b0;
  logic       gas_hi = 1'b0;
  logic [1:0] policy = 2'd0;
  logic       pump_on;
  logic       alarm;
  logic [3:0] wet_count;

  int checks = 0;
  int errors = 0;

  mine_pump_ctrl uut (
    .clk(clk), .rst_n(rst_n), .water_hi(water_hi), .gas_hi(gas_hi),
    .policy(policy), .pump_on(pump_on), .alarm(alarm), .wet_count(wet_count)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic g, input logic [1:0] p);
    @(negedge clk);
    water_hi = w;
    gas_hi   = g;
    policy   = p;
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; water_hi = 1'b0; gas_hi = 1'b0; policy = 2'd0;
    #2;
    chk("R1", "alarm in reset", alarm, 0);
    chk("R1", "wet_count in reset", wet_count, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
  endtask

  task automatic test_reset();
    do_reset();
    chk("R1", "alarm after reset", alarm, 0);
    chk("R1", "wet_count after reset", wet_count, 0);
    chk("R1", "pump after reset", pump_on, 0);
  endtask

  task automatic test_lazy_and_alarm();
    do_reset();
    cyc(1, 0, 0); chk("R6", "lazy pump at wet 0", pump_on, 0);
    chk("R10", "wet count 0", wet_count, 0);
    cyc(1, 0, 0); chk("R6", "lazy pump at wet 1", pump_on, 0);
    chk("R10", "wet count 1", wet_count, 1);
    cyc(1, 0, 0); chk("R6", "lazy pump at wet 2", pump_on, 1);
    chk("R3", "alarm after 2 wet edges", alarm, 0);
    cyc(1, 0, 0); chk("R3", "alarm after 3 wet edges", alarm, 1);
    chk("R10", "wet count 3", wet_count, 3);
    cyc(0, 0, 0); chk("R6", "lazy pump with water low", pump_on, 0);
    cyc(0, 0, 0); chk("R10", "wet count cleared", wet_count, 0);
    chk("R5", "alarm after 1 calm edge", alarm, 1);
    cyc(1, 0, 0); chk("R5", "alarm after 2 calm edges", alarm, 1);
    cyc(0, 0, 0); chk("R5", "alarm after interrupted calm", alarm, 1);
    cyc(0, 0, 0); chk("R5", "alarm after 1 new calm edge", alarm, 1);
    cyc(0, 0, 0); chk("R5", "alarm after 2 new calm edges", alarm, 1);
    cyc(0, 0, 0); chk("R5", "alarm after 3 calm edges", alarm, 0);
  endtask

  task automatic test_gas_alarm();
    do_reset();
    cyc(0, 0, 1);
    cyc(1, 1, 1); chk("R2", "eager pump blocked by gas", pump_on, 0);
    chk("R4", "alarm before gas edges", alarm, 0);
    cyc(0, 1, 1); chk("R4", "alarm after 1 gas edge", alarm, 0);
    cyc(0, 1, 1); chk("R4", "alarm after 2 gas edges", alarm, 0);
    cyc(1, 1, 1); chk("R4", "alarm after 3 gas edges", alarm, 1);
    chk("R2", "pump blocked with water and gas", pump_on, 0);
    cyc(1, 0, 1); chk("R7", "eager pump once gas clears", pump_on, 1);
  endtask

  task automatic test_gas_history();
    do_reset();
    cyc(0, 0, 2); chk("R9", "old policy still lazy", pump_on, 0);
    cyc(0, 0, 2); chk("R8", "history pump with dry mine", pump_on, 1);
    cyc(0, 1, 2); chk("R2", "history pump during gas", pump_on, 0);
    cyc(0, 0, 2); chk("R8", "gas one edge back", pump_on, 0);
    cyc(1, 0, 2); chk("R8", "gas two edges back", pump_on, 0);
    cyc(0, 0, 2); chk("R8", "gas window passed", pump_on, 1);
  endtask

  task automatic test_policy_switch();
    do_reset();
    cyc(1, 0, 1); chk("R9", "switch cycle uses lazy", pump_on, 0);
    cyc(1, 0, 1); chk("R7", "eager at wet 1", pump_on, 1);
    cyc(1, 0, 3); chk("R7", "still eager while code 3 sampled", pump_on, 1);
    do_reset();
    cyc(0, 0, 3);
    cyc(1, 0, 3); chk("R7", "code 3 acts eager at wet 0", pump_on, 1);
    cyc(1, 0, 0); chk("R9", "lazy switch not yet applied", pump_on, 1);
    cyc(1, 0, 0); chk("R6", "lazy back in force at wet 2", pump_on, 1);
    cyc(0, 0, 0); chk("R6", "lazy off with water low", pump_on, 0);
  endtask

  task automatic test_saturation();
    do_reset();
    for (int i = 0; i < 16; i++) cyc(1, 0, 0);
    chk("R10", "wet count at 15 edges", wet_count, 15);
    cyc(1, 0, 0); chk("R10", "wet count saturated", wet_count, 15);
    cyc(0, 0, 0); chk("R10", "saturated count held", wet_count, 15);
    cyc(0, 0, 0); chk("R10", "count cleared after dry edge", wet_count, 0);
  endtask

  initial begin
    test_reset();
    test_lazy_and_alarm();
    test_gas_alarm();
    test_gas_history();
    test_policy_switch();
    test_saturation();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule